// File: doc/BRIEF.md
# DTMF Tone-Pair Period-Counting Decoder

This block turns two one-bit square waves into a 4-bit keypad code. One wave comes from the limited output of the low-group band and the other from the high-group band. Each channel measures its input frequency as the number of reference-clock cycles between consecutive rising edges. It first checks each period against the four nominal tones of its group using a coarse window. A tone is accepted only when the last `NAVG` periods all fall in the same tone's window and their sum lies inside a tighter window around `NAVG` times the nominal period. Averaging in this way rejects speech-like signals and jitter while still tolerating small frequency offsets.

When both channels hold an accepted tone, `early_valid` rises and `key_code` shows the code of the pair. The flag falls as soon as either channel loses its tone. A channel loses its tone on one out-of-window period, on a period that breaks the averaged window, or when no edge arrives within the timeout. A letter-inhibit input keeps the four letter keys from raising the flag. A power-down input stops all detection.

Both outputs are plain level signals, not a stream. They have no handshake and no back-pressure. A consumer that needs a code for longer than the flag stays high must capture it itself, and must validate the tone duration itself. The reference clock is nominally 3.579545 MHz, and `CLK_HZ` sets it.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: During and after reset, and before any tone is accepted, `early_valid` is 0 and `key_code` is 4'b0000.
- R2: A measured period that deviates from every nominal period of its group by more than 3.5 % (the coarse window) marks that channel invalid at once. Low group: 697, 770, 852, 941 Hz. High group: 1209, 1336, 1477, 1633 Hz.
- R3: A channel is valid only if the sum of its last `NAVG` periods lies within ±2.5 % of `NAVG` times the nominal period. A steady 2 % offset is accepted. A steady 3 % offset is rejected. Periods that alternate ±3 % around nominal are accepted.
- R4: `early_valid` is 1 only after each channel has seen `NAVG` consecutive periods that classify to the same tone. The first edge after silence only starts measurement.
- R5: While `early_valid` is 1, `key_code` follows the keypad mapping. Rows are the low tones in rising order. Columns are the high tones in rising order. Keys 1–9 give 0001–1001, 0 gives 1010, * gives 1011, # gives 1100, A gives 1101, B gives 1110, C gives 1111 and D gives 0000.
- R6: While `letter_inhibit` is 1, a pair that uses the 1633 Hz column (A, B, C, D) drives `early_valid` to 0 from the next clock on. The other keys are unaffected.
- R7: If no rising edge arrives within 1.5 times the group's longest nominal period, that channel becomes invalid and `early_valid` falls.
- R8: While `power_down` is 1, `early_valid` is 0 from the next clock on. After release, a pair must be acquired again from scratch.
- R9: `key_code` changes only in a cycle that follows a valid, non-inhibited pair. At all other times it holds the last presented code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, `CLK_HZ` Hz |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_down | input | 1 | High stops detection and clears channel state |
| letter_inhibit | input | 1 | High masks keys in the 1633 Hz column |
| low_tone | input | 1 | Limited square wave of the low-group band |
| high_tone | input | 1 | Limited square wave of the high-group band |
| early_valid | output | 1 | High while a valid tone pair is present |
| key_code | output | 4 | Code of the present, or last presented, pair |

## Verification
A wrong run count or a stale averaging window shows at the ports as an `early_valid` that rises one or more periods too early, or never rises at all. The bench therefore samples the flag both before and after the acquisition time. A wrong window width shows as acceptance of the 3 % and 5 % offsets, or as rejection of the 2 % offset and the alternating ±3 % pattern, within about five periods of the stimulus change. A wrong code map, inhibit gate, power-down path or timeout appears on `key_code` or `early_valid` within one clock of the pair becoming valid, within one clock of the control input changing, or within 1.5 periods of the tone stopping.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int unsigned TONES_PER_GROUP = 4;

  // Nominal tone frequency in Hz; grp 0 = low band, grp 1 = high band.
  function automatic int unsigned tone_hz(int unsigned grp, int unsigned idx);
    int unsigned f;
    if (grp == 0) begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Rounded number of clock cycles in one period of freq_hz.
  function automatic int unsigned nominal_period(int unsigned clk_hz, int unsigned freq_hz);
    return (clk_hz + freq_hz / 2) / freq_hz;
  endfunction

  // Edge-silence limit: 1.5x the slowest tone of the group (index 0).
  function automatic int unsigned timeout_cycles(int unsigned clk_hz, int unsigned grp);
    return (nominal_period(clk_hz, tone_hz(grp, 0)) * 3) / 2;
  endfunction

  // Keypad code from row (low tone index) and column (high tone index).
  function automatic logic [3:0] key_of(logic [1:0] row, logic [1:0] col);
    logic [3:0] k;
    if (col == 2'd3) begin
      case (row)
        2'd0: k = 4'b1101;
        2'd1: k = 4'b1110;
        2'd2: k = 4'b1111;
        default: k = 4'b0000;
      endcase
    end else if (row == 2'd3) begin
      case (col)
        2'd0: k = 4'b1011;
        2'd1: k = 4'b1010;
        default: k = 4'b1100;
      endcase
    end else begin
      k = 4'({2'b00, row} * 4'd3 + {2'b00, col} + 4'd1);
    end
    return k;
  endfunction

endpackage

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int unsigned LW  = 16,
  parameter int unsigned TMO = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sq_in,
  output logic          per_valid,
  output logic [LW-1:0] per_len,
  output logic          tmo
);

  logic [2:0]    sync_q;
  logic          rise;
  logic          primed_q;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else if (clear) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sq_in};
    end
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      primed_q  <= 1'b0;
      per_valid <= 1'b0;
      per_len   <= '0;
      tmo       <= 1'b0;
    end else if (clear) begin
      cnt_q     <= '0;
      primed_q  <= 1'b0;
      per_valid <= 1'b0;
      tmo       <= 1'b0;
    end else begin
      per_valid <= 1'b0;
      tmo       <= 1'b0;
      if (rise) begin
        if (primed_q) begin
          per_valid <= 1'b1;
          per_len   <= cnt_q;
        end
        primed_q <= 1'b1;
        cnt_q    <= LW'(1);
      end else if (primed_q) begin
        if (32'(cnt_q) >= TMO) begin
          tmo      <= 1'b1;
          primed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + LW'(1);
        end
      end
    end
  end

  AST_PERIOD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> (32'(per_len) <= TMO)); // R7

  AST_TMO_UNPRIMES: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !per_valid); // R7

endmodule

// File: rtl/dtmf_tone_classifier.sv
module dtmf_tone_classifier #(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned GROUP   = 0,
  parameter int unsigned LW      = 16,
  parameter int unsigned NAVG    = 4,
  parameter int unsigned ACC_PPT = 25,
  parameter int unsigned REJ_PPT = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          per_valid,
  input  logic [LW-1:0] per_len,
  input  logic          tmo,
  output logic          tone_ok,
  output logic [1:0]    tone_idx
);

  localparam int unsigned NT = dtmf_pkg::TONES_PER_GROUP;
  localparam int unsigned RW = $clog2(NAVG + 1);
  localparam int unsigned HW = (NAVG > 2) ? NAVG - 1 : 1;

  logic [LW-1:0] win_q [HW];
  logic [RW-1:0] run_q;
  logic [31:0]   sum_new;
  logic [NT-1:0] hit_vec;
  logic [NT-1:0] avg_vec;
  logic          hit_any;
  logic [1:0]    hit_idx;

  // Sum of the current period and the NAVG-1 stored ones.
  always_comb begin
    sum_new = 32'(per_len);
    for (int k = 0; k < NAVG - 1; k++) begin
      sum_new = sum_new + 32'(win_q[k]);
    end
  end

  for (genvar gi = 0; gi < NT; gi++) begin : g_tone
    localparam int unsigned P  = dtmf_pkg::nominal_period(CLK_HZ, dtmf_pkg::tone_hz(GROUP, gi));
    localparam int unsigned RT = (P * REJ_PPT) / 1000;
    localparam int unsigned NP = P * NAVG;
    localparam int unsigned AT = (NP * ACC_PPT) / 1000;
    logic [31:0] len32;
    assign len32       = 32'(per_len);
    assign hit_vec[gi] = (len32 + RT >= P) && (len32 <= P + RT);
    assign avg_vec[gi] = (sum_new + AT >= NP) && (sum_new <= NP + AT);
  end

  always_comb begin
    hit_idx = 2'd0;
    for (int i = 0; i < NT; i++) begin
      if (hit_vec[i]) hit_idx = 2'(i);
    end
  end

  assign hit_any = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      tone_ok  <= 1'b0;
      tone_idx <= 2'd0;
      for (int k = 0; k < HW; k++) win_q[k] <= '0;
    end else if (clear || tmo) begin
      run_q   <= '0;
      tone_ok <= 1'b0;
    end else if (per_valid) begin
      win_q[0] <= per_len;
      for (int k = 1; k < HW; k++) win_q[k] <= win_q[k-1];
      if (!hit_any) begin
        run_q   <= '0;
        tone_ok <= 1'b0;
      end else if (run_q == '0 || hit_idx != tone_idx) begin
        tone_idx <= hit_idx;
        run_q    <= RW'(1);
        tone_ok  <= 1'b0;
      end else begin
        if (32'(run_q) < NAVG) run_q <= run_q + RW'(1);
        tone_ok <= (32'(run_q) >= NAVG - 1) && avg_vec[hit_idx];
      end
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> $onehot0(hit_vec)); // R2

  AST_BAD_PERIOD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid && !hit_any) |=> !tone_ok); // R2

  AST_SILENCE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tone_ok); // R7

  AST_OK_ON_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_ok) |-> $past(per_valid)); // R4

endmodule

// File: rtl/dtmf_pair_combiner.sv
module dtmf_pair_combiner (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       power_down,
  input  logic       letter_inhibit,
  input  logic       lo_ok,
  input  logic [1:0] lo_idx,
  input  logic       hi_ok,
  input  logic [1:0] hi_idx,
  output logic       early_valid,
  output logic [3:0] key_code
);

  logic letter;
  logic pair_ok;

  assign letter  = (hi_idx == 2'd3);
  assign pair_ok = lo_ok && hi_ok && !(letter_inhibit && letter);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_valid <= 1'b0;
      key_code    <= 4'b0000;
    end else if (power_down) begin
      early_valid <= 1'b0;
    end else begin
      early_valid <= pair_ok;
      if (pair_ok) key_code <= dtmf_pkg::key_of(lo_idx, hi_idx);
    end
  end

  AST_LETTER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (letter_inhibit && letter) |=> !early_valid); // R6

  AST_POWERDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> !early_valid); // R8

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_ok |=> $stable(key_code)); // R9

  AST_VALID_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    early_valid |-> $past(lo_ok && hi_ok)); // R4

endmodule

// File: rtl/dtmf_pair_decoder.sv
module dtmf_pair_decoder #(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned NAVG    = 4,
  parameter int unsigned ACC_PPT = 25,
  parameter int unsigned REJ_PPT = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       power_down,
  input  logic       letter_inhibit,
  input  logic       low_tone,
  input  logic       high_tone,
  output logic       early_valid,
  output logic [3:0] key_code
);

  localparam int unsigned TMO_LO = dtmf_pkg::timeout_cycles(CLK_HZ, 0);
  localparam int unsigned TMO_HI = dtmf_pkg::timeout_cycles(CLK_HZ, 1);
  localparam int unsigned LW     = $clog2(TMO_LO + 2);

  logic          lo_pv, hi_pv;
  logic [LW-1:0] lo_len, hi_len;
  logic          lo_tmo, hi_tmo;
  logic          lo_ok, hi_ok;
  logic [1:0]    lo_idx, hi_idx;

  dtmf_period_meter #(.LW(LW), .TMO(TMO_LO)) u_meter_lo (
    .clk(clk), .rst_n(rst_n), .clear(power_down), .sq_in(low_tone),
    .per_valid(lo_pv), .per_len(lo_len), .tmo(lo_tmo)
  );

  dtmf_period_meter #(.LW(LW), .TMO(TMO_HI)) u_meter_hi (
    .clk(clk), .rst_n(rst_n), .clear(power_down), .sq_in(high_tone),
    .per_valid(hi_pv), .per_len(hi_len), .tmo(hi_tmo)
  );

  dtmf_tone_classifier #(
    .CLK_HZ(CLK_HZ), .GROUP(0), .LW(LW), .NAVG(NAVG),
    .ACC_PPT(ACC_PPT), .REJ_PPT(REJ_PPT)
  ) u_class_lo (
    .clk(clk), .rst_n(rst_n), .clear(power_down), .per_valid(lo_pv),
    .per_len(lo_len), .tmo(lo_tmo), .tone_ok(lo_ok), .tone_idx(lo_idx)
  );

  dtmf_tone_classifier #(
    .CLK_HZ(CLK_HZ), .GROUP(1), .LW(LW), .NAVG(NAVG),
    .ACC_PPT(ACC_PPT), .REJ_PPT(REJ_PPT)
  ) u_class_hi (
    .clk(clk), .rst_n(rst_n), .clear(power_down), .per_valid(hi_pv),
    .per_len(hi_len), .tmo(hi_tmo), .tone_ok(hi_ok), .tone_idx(hi_idx)
  );

  dtmf_pair_combiner u_comb (
    .clk(clk), .rst_n(rst_n), .power_down(power_down),
    .letter_inhibit(letter_inhibit), .lo_ok(lo_ok), .lo_idx(lo_idx),
    .hi_ok(hi_ok), .hi_idx(hi_idx), .early_valid(early_valid),
    .key_code(key_code)
  );

  initial begin
    AST_NAVG_MIN: assert (NAVG >= 2); // R4
  end

endmodule

// File: tb/dtmf_pair_decoder_tb_top.sv
module dtmf_pair_decoder_tb_top;

  localparam int unsigned TB_CLK_HZ = 200000;
  localparam int unsigned SETTLE    = 2500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       power_down = 1'b0;
  logic       letter_inhibit = 1'b0;
  logic       low_tone = 1'b0;
  logic       high_tone = 1'b0;
  logic       early_valid;
  logic [3:0] key_code;

  int checks = 0;
  int errors = 0;
  int lo_per = 0;
  int lo_jit = 0;
  int hi_per = 0;

  always #5 clk = ~clk;

  dtmf_pair_decoder #(.CLK_HZ(TB_CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .power_down(power_down),
    .letter_inhibit(letter_inhibit), .low_tone(low_tone),
    .high_tone(high_tone), .early_valid(early_valid), .key_code(key_code)
  );

  // lo[27:17] hi[16:6] inhibit[5] exp_valid[4] exp_code[3:0]
  localparam logic [27:0] VEC [18] = '{
    {11'd697, 11'd1209, 1'b0, 1'b1, 4'b0001},
    {11'd697, 11'd1336, 1'b0, 1'b1, 4'b0010},
    {11'd697, 11'd1477, 1'b0, 1'b1, 4'b0011},
    {11'd697, 11'd1633, 1'b0, 1'b1, 4'b1101},
    {11'd770, 11'd1209, 1'b0, 1'b1, 4'b0100},
    {11'd770, 11'd1336, 1'b0, 1'b1, 4'b0101},
    {11'd770, 11'd1477, 1'b0, 1'b1, 4'b0110},
    {11'd770, 11'd1633, 1'b0, 1'b1, 4'b1110},
    {11'd852, 11'd1209, 1'b0, 1'b1, 4'b0111},
    {11'd852, 11'd1336, 1'b0, 1'b1, 4'b1000},
    {11'd852, 11'd1477, 1'b0, 1'b1, 4'b1001},
    {11'd852, 11'd1633, 1'b0, 1'b1, 4'b1111},
    {11'd941, 11'd1209, 1'b0, 1'b1, 4'b1011},
    {11'd941, 11'd1336, 1'b0, 1'b1, 4'b1010},
    {11'd941, 11'd1477, 1'b0, 1'b1, 4'b1100},
    {11'd941, 11'd1633, 1'b0, 1'b1, 4'b0000},
    {11'd852, 11'd1633, 1'b1, 1'b0, 4'b0000},
    {11'd770, 11'd1336, 1'b1, 1'b1, 4'b0101}
  };

  function automatic int per_of(int f);
    if (f == 0) return 0;
    return (TB_CLK_HZ + f / 2) / f;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pair(input int lf, input int hf);
    lo_per = per_of(lf);
    hi_per = per_of(hf);
  endtask

  // Low-band generator; the period alternates by +/- lo_jit.
  initial begin
    int p;
    bit flip;
    flip = 1'b0;
    forever begin
      if (lo_per == 0) begin
        low_tone = 1'b0;
        @(negedge clk);
      end else begin
        p = flip ? lo_per + lo_jit : lo_per - lo_jit;
        flip = !flip;
        low_tone = 1'b1;
        repeat (p / 2) @(negedge clk);
        low_tone = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  initial begin
    int p;
    forever begin
      if (hi_per == 0) begin
        high_tone = 1'b0;
        @(negedge clk);
      end else begin
        p = hi_per;
        high_tone = 1'b1;
        repeat (p / 2) @(negedge clk);
        high_tone = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    chk(early_valid == 1'b0, "R1 valid in reset", early_valid, 0);
    chk(key_code == 4'b0000, "R1 code in reset", key_code, 0);
    rst_n = 1'b1;
    wait_cyc(10);
    chk(early_valid == 1'b0 && key_code == 4'b0000, "R1 idle after reset",
        {early_valid, key_code}, 0);

    // R4: acquisition needs a priming edge plus NAVG periods
    set_pair(697, 1209);
    wait_cyc(700);
    chk(early_valid == 1'b0, "R4 too early", early_valid, 0);
    wait_cyc(SETTLE - 700);
    chk(early_valid == 1'b1, "R4 acquired", early_valid, 1);
    chk(key_code == 4'b0001, "R4 code", key_code, 1);

    // R5 / R6: vector table
    for (int v = 0; v < 18; v++) begin
      letter_inhibit = VEC[v][5];
      set_pair(int'(VEC[v][27:17]), int'(VEC[v][16:6]));
      wait_cyc(SETTLE);
      chk(early_valid == VEC[v][4], VEC[v][5] ? "R6 inhibit valid" : "R5 valid",
          early_valid, int'(VEC[v][4]));
      if (VEC[v][4])
        chk(key_code == VEC[v][3:0], VEC[v][5] ? "R6 digit code" : "R5 code",
            key_code, int'(VEC[v][3:0]));
    end
    letter_inhibit = 1'b0;

    // R6 / R9: inhibit raised while a letter pair is valid
    set_pair(697, 1633);
    wait_cyc(SETTLE);
    chk(early_valid == 1'b1 && key_code == 4'b1101, "R6 letter before inhibit",
        {early_valid, key_code}, 5'b11101);
    letter_inhibit = 1'b1;
    wait_cyc(3);
    chk(early_valid == 1'b0, "R6 inhibit drops flag", early_valid, 0);
    chk(key_code == 4'b1101, "R9 code held", key_code, 13);
    letter_inhibit = 1'b0;

    // R2 / R3: tolerance windows and averaging
    set_pair(711, 1209);
    wait_cyc(SETTLE);
    chk(early_valid == 1'b1, "R3 2pct accepted", early_valid, 1);
    chk(key_code == 4'b0001, "R3 2pct code", key_code, 1);
    set_pair(718, 1209);
    wait_cyc(SETTLE);
    chk(early_valid == 1'b0, "R3 3pct rejected", early_valid, 0);
    set_pair(732, 1209);
    wait_cyc(SETTLE);
    chk(early_valid == 1'b0, "R2 5pct rejected", early_valid, 0);
    set_pair(697, 1209);
    lo_jit = 9;
    wait_cyc(SETTLE);
    chk(early_valid == 1'b1, "R3 jitter averaged", early_valid, 1);
    lo_jit = 12;
    wait_cyc(SETTLE);
    chk(early_valid == 1'b0, "R2 jitter too wide", early_valid, 0);
    lo_jit = 0;
    wait_cyc(SETTLE);
    chk(early_valid == 1'b1, "R3 clean recovered", early_valid, 1);

    // R7 / R9: silence on the low band
    lo_per = 0;
    wait_cyc(700);
    chk(early_valid == 1'b0, "R7 timeout drops flag", early_valid, 0);
    chk(key_code == 4'b0001, "R9 code held after timeout", key_code, 1);

    // R8: power down
    set_pair(852, 1336);
    wait_cyc(SETTLE);
    chk(early_valid == 1'b1 && key_code == 4'b1000, "R8 valid before",
        {early_valid, key_code}, 5'b11000);
    power_down = 1'b1;
    wait_cyc(3);
    chk(early_valid == 1'b0, "R8 flag low", early_valid, 0);
    wait_cyc(2000);
    chk(early_valid == 1'b0, "R8 stays low", early_valid, 0);
    power_down = 1'b0;
    wait_cyc(700);
    chk(early_valid == 1'b0, "R8 reacquire not instant", early_valid, 0);
    wait_cyc(SETTLE);
    chk(early_valid == 1'b1, "R8 reacquired", early_valid, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule